// File: doc/BRIEF.md
# Auto-Request Memory-to-Memory DMA Channel

This block is a single DMA channel that copies a contiguous block of memory from a source address to a destination address. It moves one data unit per step, and every step starts internally, so no peripheral has to request it. Each unit is moved as one read on the memory master port followed by one write of the same data. The unit is 1, 2 or 4 bytes wide.

Software programs the channel through a small register port. The port holds:
- the source pointer;
- the destination pointer;
- a count of units, not bytes;
- a channel control word;
- a global operation word.

The global word holds a master enable and two sticky fault flags. While either fault flag is set, no unit starts. A copy ends by setting a done flag. The done flag raises the interrupt output when interrupts are enabled in the control word.

Top module: `dmac_auto_chan`

## Requirements
- R1: After reset every register reads zero, `irq_o` is low and `mem_req_o` is low.
- R2: Register offsets are: source pointer 0x00, destination pointer 0x04, unit count 0x08, control 0x0C, global 0x40. Control bits are: bit0 run enable (DE), bit1 done (TE), bit2 interrupt enable (IE), bits[5:4] size code. Global bits are: bit0 master enable, bit1 NMI flag, bit2 address-error flag.
- R3: No unit starts unless the master enable is 1 and both fault flags are 0. Software clears a fault flag by writing 0 to it. Writing 1 to a fault flag never sets it. Transfers resume once the gate reopens.
- R4: Each unit is one read at the source pointer (`mem_we_o`=0) followed by one write of the read data at the destination pointer (`mem_we_o`=1). `mem_size_o` carries the effective size code.
- R5: Size code 0, 1 and 2 select 1, 2 and 4 byte units, and code 3 acts as code 2. Both pointers advance by the unit size after each unit, so the final source reads start + count × unit. No byte beyond the block is written.
- R6: The count drops by one per unit. When it reaches zero, TE is set, DE stays 1 and no further unit starts. Starting with a count of zero sets TE without any bus access.
- R7: `irq_o` is high exactly while TE and IE are both 1. Writing 0 to the control register clears it.
- R8: The channel is busy while DE=1 and TE=0. While it is busy or a unit is in flight:
  - a control write with DE=1 is ignored;
  - a control write with DE=0 clears DE and loads TE and IE, but keeps the size code;
  - pointer and count writes are ignored.
- R9: If either pointer is not aligned to the unit size when a unit would start, the address-error flag is set. No bus access takes place and TE stays 0.
- R10: While `nmi_i` is high the NMI flag is set. A unit already in flight completes, and no further unit starts.
- R11: `mem_req_o`, `mem_addr_o` and `mem_we_o` stay stable until `mem_ack_i` is seen.
- R12: The count is 24 bits wide. Upper bits of a count write are dropped and read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 7 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` (combinational) |
| nmi_i | input | 1 | Non-maskable event input, sets the NMI flag |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Memory byte address |
| mem_size_o | output | 2 | log2 of the access width in bytes |
| mem_wdata_o | output | 32 | Write data, unit in the low bytes |
| mem_ack_i | input | 1 | Access accepted or completed |
| mem_rdata_i | input | 32 | Read data, unit in the low bytes |
| irq_o | output | 1 | Transfer-end interrupt |

## Verification
A wrong pointer or count shows up as soon as the block ends: the final pointers read back off by a multiple of the unit, or a destination byte outside the block changes. A stuck or premature done flag shows on `irq_o` within one cycle of the last write acknowledge. A broken gate shows as a bus request within two cycles of a control write, even though a fault flag or a zero master enable should have blocked it. Misalignment and NMI handling are visible in the global register readback and in the count, which must have stopped exactly one unit after the event.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int REG_AW = 7;
  localparam logic [REG_AW-1:0] OFS_SRC = 7'h00;
  localparam logic [REG_AW-1:0] OFS_DST = 7'h04;
  localparam logic [REG_AW-1:0] OFS_CNT = 7'h08;
  localparam logic [REG_AW-1:0] OFS_CTL = 7'h0C;
  localparam logic [REG_AW-1:0] OFS_GOP = 7'h40;

  localparam int CTL_DE = 0;
  localparam int CTL_TE = 1;
  localparam int CTL_IE = 2;
  localparam int CTL_SZ = 4;

  localparam int GOP_INIT = 0;
  localparam int GOP_NMIF = 1;
  localparam int GOP_AE   = 2;

  typedef enum logic [1:0] {XS_IDLE, XS_RD, XS_WR} xfer_state_e;
endpackage

// File: rtl/dmac_glob.sv
module dmac_glob (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [2:0] wdata_i,
  input  logic       nmi_i,
  input  logic       addr_err_i,
  output logic       init_o,
  output logic       nmif_o,
  output logic       ae_o,
  output logic       ok_o
);
  import dmac_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_o <= 1'b0;
      nmif_o <= 1'b0;
      ae_o   <= 1'b0;
    end else begin
      if (wr_i) init_o <= wdata_i[GOP_INIT];
      // flags: hardware sets, software may only clear
      nmif_o <= (nmif_o & ~(wr_i & ~wdata_i[GOP_NMIF])) | nmi_i;
      ae_o   <= (ae_o & ~(wr_i & ~wdata_i[GOP_AE])) | addr_err_i;
    end
  end

  assign ok_o = init_o & ~nmif_o & ~ae_o;
endmodule

// File: rtl/dmac_chan_regs.sv
module dmac_chan_regs #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_src_i,
  input  logic              wr_dst_i,
  input  logic              wr_cnt_i,
  input  logic              wr_ctl_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [CNT_W-1:0]  wcnt_i,
  input  logic              wde_i,
  input  logic              wte_i,
  input  logic              wie_i,
  input  logic [1:0]        wsz_i,
  input  logic              active_i,
  input  logic              unit_done_i,
  input  logic              term_i,
  input  logic [ADDR_W-1:0] step_i,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              de_o,
  output logic              te_o,
  output logic              ie_o,
  output logic [1:0]        sz_o,
  output logic              busy_o
);
  logic lock, te_set;

  assign busy_o = de_o & ~te_o;
  assign lock   = busy_o | active_i;
  assign te_set = (unit_done_i && cnt_o == CNT_W'(1)) || term_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_o <= '0;
      dst_o <= '0;
      cnt_o <= '0;
    end else if (unit_done_i) begin
      src_o <= src_o + step_i;
      dst_o <= dst_o + step_i;
      cnt_o <= cnt_o - CNT_W'(1);
    end else if (!lock) begin
      if (wr_src_i) src_o <= waddr_i;
      if (wr_dst_i) dst_o <= waddr_i;
      if (wr_cnt_i) cnt_o <= wcnt_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      de_o <= 1'b0;
      te_o <= 1'b0;
      ie_o <= 1'b0;
      sz_o <= 2'd0;
    end else if (wr_ctl_i && !lock) begin
      de_o <= wde_i;
      te_o <= wte_i | te_set;
      ie_o <= wie_i;
      sz_o <= wsz_i;
    end else if (wr_ctl_i && !wde_i) begin
      // halt write while busy: size stays frozen
      de_o <= 1'b0;
      te_o <= wte_i | te_set;
      ie_o <= wie_i;
    end else if (te_set) begin
      te_o <= 1'b1;
    end
  end
endmodule

// File: rtl/dmac_xfer.sv
module dmac_xfer #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              cnt_zero_i,
  input  logic [ADDR_W-1:0] src_i,
  input  logic [ADDR_W-1:0] dst_i,
  input  logic [1:0]        sz_i,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              active_o,
  output logic              unit_done_o,
  output logic              term_o,
  output logic              addr_err_o
);
  import dmac_pkg::*;

  xfer_state_e       state_q;
  logic [DATA_W-1:0] data_q;
  logic [ADDR_W-1:0] mask;
  logic              misalign, idle, start;

  assign mask     = (ADDR_W'(1) << sz_i) - ADDR_W'(1);
  assign misalign = ((src_i | dst_i) & mask) != '0;
  assign idle     = (state_q == XS_IDLE);
  assign term_o     = idle & run_i & cnt_zero_i;
  assign addr_err_o = idle & run_i & ~cnt_zero_i & misalign;
  assign start      = idle & run_i & ~cnt_zero_i & ~misalign;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= XS_IDLE;
      data_q  <= '0;
    end else begin
      unique case (state_q)
        XS_IDLE: if (start) state_q <= XS_RD;
        XS_RD: if (mem_ack_i) begin
          data_q  <= mem_rdata_i;
          state_q <= XS_WR;
        end
        XS_WR: if (mem_ack_i) state_q <= XS_IDLE;
        default: state_q <= XS_IDLE;
      endcase
    end
  end

  assign active_o    = ~idle;
  assign mem_req_o   = ~idle;
  assign mem_we_o    = (state_q == XS_WR);
  assign mem_addr_o  = mem_we_o ? dst_i : src_i;
  assign mem_wdata_o = data_q;
  assign unit_done_o = mem_we_o & mem_ack_i;
endmodule

// File: rtl/dmac_auto_chan.sv
module dmac_auto_chan #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [6:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              nmi_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [1:0]        mem_size_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              irq_o
);
  import dmac_pkg::*;

  localparam int MAX_SZ = $clog2(DATA_W / 8);

  logic [ADDR_W-1:0] src_q, dst_q, step;
  logic [CNT_W-1:0]  cnt_q;
  logic              de_q, te_q, ie_q, busy;
  logic [1:0]        sz_q, eff_sz;
  logic              g_init, g_nmif, g_ae, gop_ok;
  logic              active, unit_done, term, addr_err, run;

  assign eff_sz = (int'(sz_q) > MAX_SZ) ? 2'(MAX_SZ) : sz_q;
  assign step   = ADDR_W'(1) << eff_sz;
  assign run    = de_q & ~te_q & gop_ok;

  dmac_glob u_glob (
    .clk_i, .rst_ni,
    .wr_i       (reg_wr_i && reg_addr_i == OFS_GOP),
    .wdata_i    (reg_wdata_i[2:0]),
    .nmi_i,
    .addr_err_i (addr_err),
    .init_o     (g_init),
    .nmif_o     (g_nmif),
    .ae_o       (g_ae),
    .ok_o       (gop_ok)
  );

  dmac_chan_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni,
    .wr_src_i    (reg_wr_i && reg_addr_i == OFS_SRC),
    .wr_dst_i    (reg_wr_i && reg_addr_i == OFS_DST),
    .wr_cnt_i    (reg_wr_i && reg_addr_i == OFS_CNT),
    .wr_ctl_i    (reg_wr_i && reg_addr_i == OFS_CTL),
    .waddr_i     (reg_wdata_i[ADDR_W-1:0]),
    .wcnt_i      (reg_wdata_i[CNT_W-1:0]),
    .wde_i       (reg_wdata_i[CTL_DE]),
    .wte_i       (reg_wdata_i[CTL_TE]),
    .wie_i       (reg_wdata_i[CTL_IE]),
    .wsz_i       (reg_wdata_i[CTL_SZ+:2]),
    .active_i    (active),
    .unit_done_i (unit_done),
    .term_i      (term),
    .step_i      (step),
    .src_o       (src_q),
    .dst_o       (dst_q),
    .cnt_o       (cnt_q),
    .de_o        (de_q),
    .te_o        (te_q),
    .ie_o        (ie_q),
    .sz_o        (sz_q),
    .busy_o      (busy)
  );

  dmac_xfer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_xfer (
    .clk_i, .rst_ni,
    .run_i       (run),
    .cnt_zero_i  (cnt_q == '0),
    .src_i       (src_q),
    .dst_i       (dst_q),
    .sz_i        (eff_sz),
    .mem_ack_i,
    .mem_rdata_i,
    .mem_req_o,
    .mem_we_o,
    .mem_addr_o,
    .mem_wdata_o,
    .active_o    (active),
    .unit_done_o (unit_done),
    .term_o      (term),
    .addr_err_o  (addr_err)
  );

  assign mem_size_o = eff_sz;
  assign irq_o      = te_q & ie_q;

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      OFS_SRC: reg_rdata_o = 32'(src_q);
      OFS_DST: reg_rdata_o = 32'(dst_q);
      OFS_CNT: reg_rdata_o = 32'(cnt_q);
      OFS_CTL: begin
        reg_rdata_o[CTL_DE]     = de_q;
        reg_rdata_o[CTL_TE]     = te_q;
        reg_rdata_o[CTL_IE]     = ie_q;
        reg_rdata_o[CTL_SZ+:2]  = sz_q;
      end
      OFS_GOP: reg_rdata_o = {29'd0, g_ae, g_nmif, g_init};
      default: reg_rdata_o = '0;
    endcase
  end

  logic unused_busy;
  assign unused_busy = busy;
endmodule

// File: rtl/dmac_auto_chan_chk.sv
module dmac_auto_chan_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic              mem_ack_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [1:0]        mem_size_o,
  input logic              unit_done_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic              te_i,
  input logic              ok_i
);
  logic [ADDR_W-1:0] amask;
  assign amask = (ADDR_W'(1) << mem_size_o) - ADDR_W'(1);

  AST_HALT_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ok_i && !mem_req_o) |=> !mem_req_o);  // R3
  AST_READ_FIRST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> !mem_we_o);  // R4
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unit_done_i |=> cnt_i == $past(cnt_i) - CNT_W'(1));  // R6
  AST_DONE_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (te_i && !mem_req_o) |=> !mem_req_o);  // R6
  AST_ALIGNED_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o & amask) == '0);  // R9
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));  // R11
endmodule

bind dmac_auto_chan dmac_auto_chan_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_ack_i   (mem_ack_i),
  .mem_addr_o  (mem_addr_o),
  .mem_size_o  (mem_size_o),
  .unit_done_i (unit_done),
  .cnt_i       (cnt_q),
  .te_i        (te_q),
  .ok_i        (gop_ok)
);

// File: tb/dmac_auto_chan_test.sv
module dmac_auto_chan_test;
  localparam logic [6:0] A_SRC = 7'h00, A_DST = 7'h04, A_CNT = 7'h08,
                         A_CTL = 7'h0C, A_GOP = 7'h40;

  localparam int NV = 4;
  localparam logic [1:0]  V_SZ  [NV] = '{2'd0, 2'd1, 2'd2, 2'd3};
  localparam logic [31:0] V_SRC [NV] = '{32'h10, 32'h20, 32'h30, 32'h40};
  localparam logic [31:0] V_DST [NV] = '{32'h80, 32'h90, 32'hA0, 32'hC0};
  localparam logic [31:0] V_CNT [NV] = '{32'd5, 32'd4, 32'd3, 32'd2};
  localparam logic [31:0] V_ESRC[NV] = '{32'h15, 32'h28, 32'h3C, 32'h48};
  localparam logic [31:0] V_EDST[NV] = '{32'h85, 32'h98, 32'hAC, 32'hC8};

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        nmi = 1'b0;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_size;
  logic        irq;
  logic        ack_en = 1'b1, fill_req = 1'b0;
  logic [7:0]  mem [256];
  int          req_cnt = 0;
  int          n_tests = 0, n_fail = 0;

  always #4 clk = ~clk;

  dmac_auto_chan uut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .nmi_i(nmi),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_size_o(mem_size), .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack),
    .mem_rdata_i(mem_rdata), .irq_o(irq)
  );

  function automatic logic [7:0] pat(input logic [7:0] a);
    return a ^ 8'hA5;
  endfunction

  assign mem_ack = mem_req & ack_en;
  assign mem_rdata = {mem[mem_addr[7:0] + 8'd3], mem[mem_addr[7:0] + 8'd2],
                      mem[mem_addr[7:0] + 8'd1], mem[mem_addr[7:0]]};

  always @(posedge clk) begin
    if (fill_req) begin
      for (int i = 0; i < 256; i++) mem[i] <= pat(8'(i));
    end else if (mem_req && mem_we && mem_ack) begin
      for (int b = 0; b < (1 << mem_size); b++)
        mem[mem_addr[7:0] + 8'(b)] <= mem_wdata[8*b +: 8];
    end
    if (mem_req) req_cnt <= req_cnt + 1;
  end

  task automatic check(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic fill();
    @(negedge clk); fill_req = 1'b1;
    @(negedge clk); fill_req = 1'b0;
  endtask

  task automatic wait_te();
    logic [31:0] c;
    for (int i = 0; i < 4000; i++) begin
      rd(A_CTL, c);
      if (c[1]) break;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int r0;
    idle(3);
    rst_n = 1'b1;
    fill();

    // R1 reset state
    rd(A_SRC, v); check("R1 src", v, 0);
    rd(A_DST, v); check("R1 dst", v, 0);
    rd(A_CNT, v); check("R1 cnt", v, 0);
    rd(A_CTL, v); check("R1 ctl", v, 0);
    rd(A_GOP, v); check("R1 gop", v, 0);
    check("R1 irq", {31'd0, irq}, 0);
    check("R1 req", {31'd0, mem_req}, 0);

    // R12 count width
    wr(A_CNT, 32'hFFFF_FFFF); rd(A_CNT, v); check("R12 cnt width", v, 32'h00FF_FFFF);
    wr(A_CNT, 0);

    // R2 R4 R5 R6 R7 vector table
    for (int k = 0; k < NV; k++) begin
      int bytes;
      logic bad;
      bytes = int'(V_CNT[k]) << ((V_SZ[k] == 2'd3) ? 2 : V_SZ[k]);
      fill();
      wr(A_GOP, 32'h1);
      wr(A_SRC, V_SRC[k]); wr(A_DST, V_DST[k]); wr(A_CNT, V_CNT[k]);
      wr(A_CTL, {26'd0, V_SZ[k], 4'b0101});
      wait_te();
      rd(A_SRC, v); check("R5 final src", v, V_ESRC[k]);
      rd(A_DST, v); check("R5 final dst", v, V_EDST[k]);
      rd(A_CNT, v); check("R6 cnt zero", v, 0);
      rd(A_CTL, v); check("R2 R6 ctl done", v, {26'd0, V_SZ[k], 4'b0111});
      check("R7 irq set", {31'd0, irq}, 1);
      bad = 1'b0;
      for (int b = 0; b < bytes; b++)
        if (mem[V_DST[k][7:0] + 8'(b)] !== pat(V_SRC[k][7:0] + 8'(b))) bad = 1'b1;
      check("R4 copied bytes", {31'd0, bad}, 0);
      check("R5 no overrun", {24'd0, mem[V_DST[k][7:0] + 8'(bytes)]},
            {24'd0, pat(V_DST[k][7:0] + 8'(bytes))});
      wr(A_CTL, 0);
      check("R7 irq cleared", {31'd0, irq}, 0);
    end

    // R3 gate: flags not settable, no transfer without INIT
    wr(A_GOP, 32'h6); rd(A_GOP, v); check("R3 flags not settable", v, 0);
    fill();
    r0 = req_cnt;
    wr(A_SRC, 32'h10); wr(A_DST, 32'h80); wr(A_CNT, 3); wr(A_CTL, 32'h1);
    idle(20);
    check("R3 no req when disabled", req_cnt - r0, 0);
    rd(A_CNT, v); check("R3 cnt held", v, 3);
    wr(A_GOP, 32'h1);
    wait_te();
    rd(A_CNT, v); check("R3 resumes", v, 0);
    wr(A_CTL, 0);

    // R6 zero count
    r0 = req_cnt;
    wr(A_CNT, 0); wr(A_CTL, 32'h1);
    idle(5);
    rd(A_CTL, v); check("R6 zero count te", v, 32'h3);
    check("R6 zero count no bus", req_cnt - r0, 0);
    check("R7 irq needs IE", {31'd0, irq}, 0);
    wr(A_CTL, 0);

    // R9 misaligned
    r0 = req_cnt;
    wr(A_SRC, 32'h31); wr(A_DST, 32'hA0); wr(A_CNT, 2); wr(A_CTL, 32'h21);
    idle(10);
    rd(A_GOP, v); check("R9 ae set", v, 32'h5);
    rd(A_CTL, v); check("R9 te clear", v, 32'h21);
    check("R9 no bus", req_cnt - r0, 0);
    wr(A_CTL, 0); rd(A_CTL, v); check("R8 de clear while busy", v, 32'h20);
    wr(A_GOP, 32'h1); rd(A_GOP, v); check("R3 clear by zero", v, 32'h1);

    // R10 R11 NMI during stalled unit
    fill();
    ack_en = 1'b0;
    wr(A_SRC, 32'h10); wr(A_DST, 32'h80); wr(A_CNT, 8); wr(A_CTL, 32'h05);
    idle(3);
    check("R11 req held", {31'd0, mem_req}, 1);
    check("R11 read first", {31'd0, mem_we}, 0);
    check("R11 addr held", mem_addr, 32'h10);
    @(negedge clk); nmi = 1'b1;
    @(negedge clk); nmi = 1'b0;
    idle(2);
    ack_en = 1'b1;
    idle(10);
    rd(A_GOP, v); check("R10 nmif set", v, 32'h3);
    rd(A_CNT, v); check("R10 in-flight unit done", v, 7);
    check("R10 byte copied", {24'd0, mem[8'h80]}, {24'd0, pat(8'h10)});
    check("R10 next unit blocked", {24'd0, mem[8'h81]}, {24'd0, pat(8'h81)});
    wr(A_SRC, 0); rd(A_SRC, v); check("R8 src write ignored", v, 32'h11);
    wr(A_CTL, 32'h01); rd(A_CTL, v); check("R8 ctl write ignored", v, 32'h05);
    wr(A_GOP, 32'h1);
    wait_te();
    rd(A_CNT, v); check("R10 resume cnt", v, 0);
    rd(A_SRC, v); check("R10 resume src", v, 32'h18);
    check("R7 irq", {31'd0, irq}, 1);
    wr(A_CTL, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule